// File: doc/BRIEF.md
# Stereo Serial-Controlled Volume Attenuator

This block scales a pair of parallel 24-bit two's-complement sample streams (left and right) by a per-channel gain that is set through a three-wire write-only control port. The port consists of a control clock, a control data line and a latch line. A 16-bit word is shifted in MSB first, and a rising edge on the latch line commits it to the channel that the word names. Each word carries a 10-bit volume code and a soft-mute bit for that one channel. The gain applied is the code divided by 1024, so the volume control has 1024 steps.

Mute never switches gain abruptly. Each channel has a live gain register that moves one code step per sample toward its target. The target is zero when the channel is muted, either by its soft-mute bit or by the shared hardware mute pin, and is the volume code otherwise. The control pins are oversampled in the system clock domain, so the control clock may be continuous or gated.

A power-down input, active low, holds every register at its default while it is low. On release the block starts again from full gain with no mute. The usual integration is behind a serial audio receiver and ahead of an interpolation filter, with the sample strobe marking each stereo frame.

Top module: `stereo_vol_ctrl`

## Requirements
- R1: After `rst` and after a power-down, both channels hold volume code 1023, soft mute off and live gain 1023. `out_l`, `out_r` and `out_vld` are zero until the first sample.
- R2: On a cycle with `smp_vld` high, each output becomes round((x*g)/1024) on the next edge. Here x is the signed sample, g is the live gain, and rounding is (x*g + 512) arithmetically shifted right by 10. `out_vld` is high for exactly that one cycle, and the outputs hold their value between samples.
- R3: Control data is sampled on each rising edge of `ctl_clk`, MSB first. A rising edge of `ctl_lat` commits the last 16 bits. In the word, bit 15 selects the channel (0 left, 1 right), bit 14 is the soft-mute bit for that channel, and bits 9:0 are the volume code.
- R4: Word bits 13:10 have no effect on either channel.
- R5: A latch edge that follows fewer than 16 control-clock edges since the previous latch discards the word. With more than 16 edges, the last 16 bits are used.
- R6: The live gain changes only on sample cycles and by exactly one code step toward the target, with no jump.
- R7: While `hw_mute` is high, the target of both channels is zero. When it goes low, each channel's target returns to its own volume code, or to zero if that channel is soft-muted.
- R8: A write to one channel leaves the other channel's volume, mute and output unchanged.
- R9: While `pd_n` is low, the outputs stay zero, `out_vld` stays low, and control writes are discarded.
- R10: A live gain of zero gives an exactly zero output for every input, including the most negative sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_n | input | 1 | Power-down, active low; holds defaults while low |
| ctl_clk | input | 1 | Control-port shift clock (may be gated) |
| ctl_dat | input | 1 | Control-port serial data, MSB first |
| ctl_lat | input | 1 | Control-port latch; rising edge commits the word |
| hw_mute | input | 1 | Hardware mute for both channels |
| smp_vld | input | 1 | Input sample strobe for one stereo frame |
| smp_l | input | 24 | Left input sample, two's complement |
| smp_r | input | 24 | Right input sample, two's complement |
| out_vld | output | 1 | Output sample strobe, one cycle after `smp_vld` |
| out_l | output | 24 | Attenuated left sample |
| out_r | output | 24 | Attenuated right sample |

## Verification
The checker watches these properties on every cycle:
- the live gains move by at most one step, and only on sample cycles;
- the output strobe tracks the input strobe;
- hardware mute never lets a gain rise;
- a zero gain always yields a zero output;
- power-down forces quiet outputs.

Other behaviours can only be shown by the bench's scenarios, which follow complete ramps sample by sample against an arithmetic model of the gain:
- the exact rounding of the product;
- the decoding of the channel, mute and volume fields;
- the discarding of short words and of reserved bits;
- channel independence;
- the return to defaults after a power-down.

// File: rtl/vc_pkg.sv
package vc_pkg;

    localparam int SMP_W    = 24;
    localparam int VOL_W    = 10;
    localparam int WORD_W   = 16;
    localparam int CH_COUNT = 2;

    localparam int CH_BIT   = WORD_W - 1;
    localparam int MUTE_BIT = WORD_W - 2;
    localparam int CNT_W    = $clog2(WORD_W + 1);
    localparam int PROD_W   = SMP_W + VOL_W + 1;

    localparam logic [VOL_W-1:0] VOL_DEFAULT = '1;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    typedef struct packed {
        chan_e            ch;
        logic             mute;
        logic [VOL_W-1:0] vol;
    } ctl_wr_t;

    typedef logic signed [SMP_W-1:0] sample_t;

    function automatic logic [VOL_W-1:0] gain_step(
        input logic [VOL_W-1:0] cur,
        input logic [VOL_W-1:0] tgt
    );
        if (cur < tgt)
            return cur + 1'b1;
        else if (cur > tgt)
            return cur - 1'b1;
        else
            return cur;
    endfunction

    function automatic sample_t apply_gain(
        input sample_t          x,
        input logic [VOL_W-1:0] g
    );
        logic signed [PROD_W-1:0] xe;
        logic signed [PROD_W-1:0] ge;
        logic signed [PROD_W-1:0] p;
        xe = PROD_W'(x);
        ge = PROD_W'($signed({1'b0, g}));
        p  = xe * ge + (PROD_W'(1) <<< (VOL_W - 1));
        return SMP_W'(p >>> VOL_W);
    endfunction

endpackage

// File: rtl/vc_sync.sv
module vc_sync #(
    parameter int STAGES = 2,
    parameter int W      = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++)
                st[i] <= '0;
        end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++)
                st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/vc_ctl_port.sv
module vc_ctl_port
    import vc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    ctl_clk,
    input  logic    ctl_dat,
    input  logic    ctl_lat,
    output logic    wr_vld,
    output ctl_wr_t wr
);
    logic [2:0]        syn;
    logic              s_dat, s_clk, s_lat;
    logic              prev_clk, prev_lat;
    logic              clk_rise, lat_rise;
    logic [WORD_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;
    logic              rsv_unused;

    vc_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ctl_lat, ctl_clk, ctl_dat}),
        .q   (syn)
    );

    assign {s_lat, s_clk, s_dat} = syn;
    assign clk_rise   = s_clk & ~prev_clk;
    assign lat_rise   = s_lat & ~prev_lat;
    // reserved field of the word is ignored by design
    assign rsv_unused = ^sh[MUTE_BIT-1:VOL_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_clk <= 1'b0;
            prev_lat <= 1'b0;
            sh       <= '0;
            cnt      <= '0;
            wr_vld   <= 1'b0;
            wr       <= '{ch: CH_LEFT, mute: 1'b0, vol: VOL_DEFAULT};
        end else begin
            prev_clk <= s_clk;
            prev_lat <= s_lat;
            wr_vld   <= 1'b0;
            if (lat_rise) begin
                wr_vld  <= (cnt == CNT_W'(WORD_W));
                wr.ch   <= chan_e'(sh[CH_BIT]);
                wr.mute <= sh[MUTE_BIT];
                wr.vol  <= sh[VOL_W-1:0];
                cnt     <= '0;
            end else if (clk_rise) begin
                sh <= {sh[WORD_W-2:0], s_dat};
                if (cnt != CNT_W'(WORD_W))
                    cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/vc_chan.sv
module vc_chan
    import vc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_mute,
    input  logic [VOL_W-1:0] wr_vol,
    input  logic             hw_mute,
    input  logic             smp_vld,
    input  sample_t          smp_in,
    output sample_t          smp_out,
    output logic [VOL_W-1:0] gain_o
);
    logic [VOL_W-1:0] vol_q;
    logic             mute_q;
    logic [VOL_W-1:0] gain_q;
    logic [VOL_W-1:0] target;

    assign target = (mute_q | hw_mute) ? '0 : vol_q;
    assign gain_o = gain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vol_q  <= VOL_DEFAULT;
            mute_q <= 1'b0;
        end else if (wr_en) begin
            vol_q  <= wr_vol;
            mute_q <= wr_mute;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gain_q  <= VOL_DEFAULT;
            smp_out <= '0;
        end else if (smp_vld) begin
            smp_out <= apply_gain(smp_in, gain_q);
            gain_q  <= gain_step(gain_q, target);
        end
    end
endmodule

// File: rtl/stereo_vol_ctrl.sv
module stereo_vol_ctrl
    import vc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pd_n,
    input  logic             ctl_clk,
    input  logic             ctl_dat,
    input  logic             ctl_lat,
    input  logic             hw_mute,
    input  logic             smp_vld,
    input  logic [SMP_W-1:0] smp_l,
    input  logic [SMP_W-1:0] smp_r,
    output logic             out_vld,
    output logic [SMP_W-1:0] out_l,
    output logic [SMP_W-1:0] out_r
);
    logic             rst_all;
    logic             wr_vld;
    ctl_wr_t          wr;
    sample_t          in_a   [CH_COUNT];
    sample_t          out_a  [CH_COUNT];
    logic [VOL_W-1:0] gain_a [CH_COUNT];
    logic [VOL_W-1:0] gain_l, gain_r;

    assign rst_all = rst | ~pd_n;

    vc_ctl_port #(.SYNC_STAGES(SYNC_STAGES)) u_port (
        .clk     (clk),
        .rst     (rst_all),
        .ctl_clk (ctl_clk),
        .ctl_dat (ctl_dat),
        .ctl_lat (ctl_lat),
        .wr_vld  (wr_vld),
        .wr      (wr)
    );

    assign in_a[0] = sample_t'(smp_l);
    assign in_a[1] = sample_t'(smp_r);

    for (genvar c = 0; c < CH_COUNT; c++) begin : g_ch
        vc_chan u_ch (
            .clk     (clk),
            .rst     (rst_all),
            .wr_en   (wr_vld && (int'(wr.ch) == c)),
            .wr_mute (wr.mute),
            .wr_vol  (wr.vol),
            .hw_mute (hw_mute),
            .smp_vld (smp_vld),
            .smp_in  (in_a[c]),
            .smp_out (out_a[c]),
            .gain_o  (gain_a[c])
        );
    end

    assign out_l  = out_a[0];
    assign out_r  = out_a[1];
    assign gain_l = gain_a[0];
    assign gain_r = gain_a[1];

    always_ff @(posedge clk) begin
        if (rst_all)
            out_vld <= 1'b0;
        else
            out_vld <= smp_vld;
    end
endmodule

module vc_chk
    import vc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             pd_n,
    input logic             hw_mute,
    input logic             smp_vld,
    input logic             out_vld,
    input logic [SMP_W-1:0] out_l,
    input logic [SMP_W-1:0] out_r,
    input logic [VOL_W-1:0] gain_l,
    input logic [VOL_W-1:0] gain_r
);
    // R6
    gain_idle_chk: assert property (@(posedge clk) disable iff (rst || !pd_n)
        !smp_vld |=> ($stable(gain_l) && $stable(gain_r)));

    // R6
    gain_step_chk: assert property (@(posedge clk) disable iff (rst || !pd_n)
        smp_vld |=> ((gain_l == $past(gain_l)) || (gain_l == $past(gain_l) + 1'b1)
                     || (gain_l + 1'b1 == $past(gain_l)))
                 && ((gain_r == $past(gain_r)) || (gain_r == $past(gain_r) + 1'b1)
                     || (gain_r + 1'b1 == $past(gain_r))));

    // R2
    out_strobe_chk: assert property (@(posedge clk) disable iff (rst || !pd_n)
        smp_vld |=> out_vld);

    // R2
    out_quiet_chk: assert property (@(posedge clk) disable iff (rst || !pd_n)
        !smp_vld |=> !out_vld);

    // R7
    hw_mute_fall_chk: assert property (@(posedge clk) disable iff (rst || !pd_n)
        (hw_mute && smp_vld) |=> (gain_l <= $past(gain_l)) && (gain_r <= $past(gain_r)));

    // R10
    zero_gain_chk: assert property (@(posedge clk) disable iff (rst || !pd_n)
        (smp_vld && gain_l == '0) |=> (out_l == '0));

    // R9
    pwr_down_chk: assert property (@(posedge clk) disable iff (rst)
        !pd_n |=> (!out_vld && out_l == '0 && out_r == '0));
endmodule

bind stereo_vol_ctrl vc_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .pd_n    (pd_n),
    .hw_mute (hw_mute),
    .smp_vld (smp_vld),
    .out_vld (out_vld),
    .out_l   (out_l),
    .out_r   (out_r),
    .gain_l  (gain_l),
    .gain_r  (gain_r)
);

// File: tb/sim_stereo_vol_ctrl.sv
module sim_stereo_vol_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pd_n = 1'b1;
    logic        ctl_clk = 1'b0, ctl_dat = 1'b0, ctl_lat = 1'b0;
    logic        hw_mute = 1'b0;
    logic        smp_vld = 1'b0;
    logic [23:0] smp_l = '0, smp_r = '0;
    logic        out_vld;
    logic [23:0] out_l, out_r;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model of the channel state
    int  m_vol [2];
    bit  m_mute[2];
    int  m_gain[2];
    bit  m_hw = 0;
    int  sidx = 0;

    always #10 clk = ~clk;

    stereo_vol_ctrl u0 (
        .clk(clk), .rst(rst), .pd_n(pd_n),
        .ctl_clk(ctl_clk), .ctl_dat(ctl_dat), .ctl_lat(ctl_lat),
        .hw_mute(hw_mute), .smp_vld(smp_vld), .smp_l(smp_l), .smp_r(smp_r),
        .out_vld(out_vld), .out_l(out_l), .out_r(out_r)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_defaults();
        for (int c = 0; c < 2; c++) begin
            m_vol[c] = 1023; m_mute[c] = 0; m_gain[c] = 1023;
        end
    endtask

    function automatic int pat(input int i);
        logic [31:0] v;
        logic [23:0] t;
        if (i % 7 == 0) return -8388608;
        if (i % 7 == 1) return 8388607;
        v = i * 32'd1103515245 + 32'd12345;
        t = v[30:7];
        return int'($signed(t));
    endfunction

    function automatic longint expv(input int x, input int g);
        longint p;
        p = longint'(x) * g + 512;
        return p >>> 10;
    endfunction

    // one stereo frame, checked against the model, then model gains step
    task automatic do_sample(input string req);
        int xl, xr, tgt;
        xl = pat(sidx); xr = pat(sidx + 3); sidx++;
        @(negedge clk);
        smp_vld = 1'b1; smp_l = xl[23:0]; smp_r = xr[23:0];
        @(negedge clk);
        smp_vld = 1'b0;
        if (pd_n) begin
            chk(out_vld == 1'b1, req, "out_vld", out_vld, 1);
            chk(longint'($signed(out_l)) == expv(xl, m_gain[0]), req, "out_l",
                longint'($signed(out_l)), expv(xl, m_gain[0]));
            chk(longint'($signed(out_r)) == expv(xr, m_gain[1]), req, "out_r",
                longint'($signed(out_r)), expv(xr, m_gain[1]));
            for (int c = 0; c < 2; c++) begin
                tgt = (m_hw || m_mute[c]) ? 0 : m_vol[c];
                if (m_gain[c] < tgt) m_gain[c]++;
                else if (m_gain[c] > tgt) m_gain[c]--;
            end
        end else begin
            chk(out_vld == 1'b0, req, "pd out_vld", out_vld, 0);
            chk(out_l == 24'd0 && out_r == 24'd0, req, "pd outputs zero",
                longint'(out_l | out_r), 0);
        end
    endtask

    task automatic run(input int n, input string req);
        for (int i = 0; i < n; i++) do_sample(req);
    endtask

    task automatic send(input logic [31:0] w, input int n);
        for (int b = n - 1; b >= 0; b--) begin
            ctl_dat = w[b];
            repeat (4) @(negedge clk);
            ctl_clk = 1'b1;
            repeat (4) @(negedge clk);
            ctl_clk = 1'b0;
            repeat (4) @(negedge clk);
        end
        ctl_lat = 1'b1;
        repeat (4) @(negedge clk);
        ctl_lat = 1'b0;
        repeat (6) @(negedge clk);
        if (n >= 16 && pd_n) begin
            m_mute[w[15]] = w[14];
            m_vol[w[15]]  = int'(w[9:0]);
        end
    endtask

    initial begin
        model_defaults();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk(out_vld == 1'b0, "R1", "reset out_vld", out_vld, 0);
        chk(out_l == 24'd0, "R1", "reset out_l", out_l, 0);
        chk(out_r == 24'd0, "R1", "reset out_r", out_r, 0);
        // R1 R2 default full gain
        run(14, "R2");
        // R3 R6 R10 R8: left volume 0, ramp all the way down, right untouched
        send(32'h0000_0000, 16);
        run(1030, "R6");
        run(8, "R10");
        // R4: reserved bits set, left volume 512
        send(32'h0000_3C00 | 32'd512, 16);
        run(520, "R4");
        // R5: 15-bit partial word (left volume 0) discarded
        send(32'h0000_0000, 15);
        run(10, "R5");
        // R5: 17 edges, last 16 select right volume 700
        send(32'h0001_8000 | 32'd700, 17);
        run(330, "R5");
        // R3 R8: soft mute right only
        send(32'h0000_C000 | 32'd1023, 16);
        run(710, "R8");
        // R7: hardware mute, then release (right stays soft-muted)
        @(negedge clk); hw_mute = 1'b1; m_hw = 1;
        run(520, "R7");
        @(negedge clk); hw_mute = 1'b0; m_hw = 0;
        run(520, "R7");
        // R9: power-down, a write during it is discarded
        @(negedge clk); pd_n = 1'b0;
        repeat (2) @(negedge clk);
        run(3, "R9");
        send(32'h0000_0000, 16);
        run(2, "R9");
        @(negedge clk); pd_n = 1'b1;
        model_defaults();
        repeat (2) @(negedge clk);
        chk(out_vld == 1'b0 && out_l == 24'd0, "R1", "after power-down",
            longint'(out_l), 0);
        run(12, "R9");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule